// File: doc/BRIEF.md
# Sixteen-bit ALU with flag register

This block is the arithmetic and logic datapath of a small accumulator-style processor. Two operand words and a four-bit operation code enter; the block returns, in the same cycle, a truncated result word and a write-back enable for the register file. A three-bit condition register is written on the next rising clock edge whenever the instruction asks for it through `flag_we`. Conditional branches elsewhere in the processor read that register.

The arithmetic comes in two kinds. The signed kind reports two's-complement range violation in the overflow bit. The logical kind reports carry or borrow out of the word in that bit and never sets the sign bit. Bitwise operations and the pass-through load set zero and sign and always clear the overflow bit. The two compare operations produce the difference a minus b on `result` but hold `wb_en` low, so only the flags change. Operation codes outside the assigned set do nothing.

Top module: `alu16_flagged`

## Requirements
- R1: Arithmetic results are truncated to 16 bits. Signed add (op 1) and logical add (op 3) return a+b. Signed subtract (op 2) and logical subtract (op 4) return a-b.
- R2: AND (op 5), OR (op 6) and XOR (op 7) return the bitwise combination of a and b. Load (op 0) returns b unchanged.
- R3: The flag word is {zero, sign, overflow} at bits 2, 1 and 0. After signed add or subtract with `flag_we` high, zero is set when the 16-bit result is 0 and sign equals result bit 15. Overflow is set when the true signed result lies outside -32768..32767.
- R4: After logical add or subtract with `flag_we` high, zero follows the 16-bit result and the sign bit is 0. Overflow holds the carry out of bit 15 for add, or the borrow (a < b as unsigned) for subtract.
- R5: After AND, OR, XOR or load with `flag_we` high, zero and sign follow the result and the overflow bit is 0, even if it was 1 before.
- R6: Signed compare (op 8) and logical compare (op 9) drive a-b on `result` and keep `wb_en` at 0. With `flag_we` high they set the flags exactly as signed or logical subtract would.
- R7: `wb_en` is 1 for ops 0 to 7.
- R8: With `flag_we` low, the flag register keeps its value across the clock edge whatever the op.
- R9: With `rst` high at a rising edge, the flag register becomes 000 (synchronous reset).
- R10: Unassigned op codes (10 to 15) drive `result` to 0 and `wb_en` to 0. They leave the flag register unchanged even with `flag_we` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flag register |
| rst | input | 1 | Synchronous active-high reset of the flags |
| a | input | 16 | First operand (minuend for subtract and compare) |
| b | input | 16 | Second operand; source for load |
| op | input | 4 | Operation code |
| flag_we | input | 1 | Write the new flags on the next rising edge |
| result | output | 16 | Combinational result word |
| wb_en | output | 1 | Result should be written back |
| flags | output | 3 | Registered {zero, sign, overflow} |

## Verification
The checker watches the following on every cycle:
- compares and unassigned codes never raise `wb_en`;
- load passes b through;
- a disabled write or an unassigned code leaves the flags untouched;
- the zero flag follows the result that was present when the write happened;
- logical arithmetic clears the sign bit, and bitwise ops and loads clear the overflow bit;
- a same-sign signed add whose result changes sign raises overflow;
- reset empties the register.

Only the directed scenarios show the exact values at the boundaries: 0x7FFF+1 and 0x8000-1 in signed mode, carry and borrow in logical mode, and overflow being cleared after it was set. They also show that a compare yields the same flags as the matching subtract.

// File: rtl/alu16_pkg.sv
package alu16_pkg;
  localparam int OP_W   = 4;
  localparam int FLAG_W = 3;
  localparam int FLG_ZERO = 2;
  localparam int FLG_SIGN = 1;
  localparam int FLG_OVF  = 0;

  typedef enum logic [OP_W-1:0] {
    OP_LOAD  = 4'd0,
    OP_ADDS  = 4'd1,
    OP_SUBS  = 4'd2,
    OP_ADDU  = 4'd3,
    OP_SUBU  = 4'd4,
    OP_AND   = 4'd5,
    OP_OR    = 4'd6,
    OP_XOR   = 4'd7,
    OP_CMPS  = 4'd8,
    OP_CMPU  = 4'd9
  } alu_op_e;

  typedef enum logic [1:0] {
    BW_PASS = 2'd0,
    BW_AND  = 2'd1,
    BW_OR   = 2'd2,
    BW_XOR  = 2'd3
  } bw_sel_e;

  typedef struct packed {
    logic    valid;
    logic    is_arith;
    logic    is_sub;
    logic    is_signed;
    logic    is_cmp;
    bw_sel_e bw_sel;
  } alu_ctrl_t;
endpackage

// File: rtl/alu16_decode.sv
module alu16_decode
  import alu16_pkg::*;
(
  input  logic [OP_W-1:0] op,
  output alu_ctrl_t       ctrl
);
  always_comb begin
    ctrl = '0;
    ctrl.bw_sel = BW_PASS;
    case (alu_op_e'(op))
      OP_LOAD: begin ctrl.valid = 1'b1; ctrl.bw_sel = BW_PASS; end
      OP_ADDS: begin ctrl.valid = 1'b1; ctrl.is_arith = 1'b1; ctrl.is_signed = 1'b1; end
      OP_SUBS: begin ctrl.valid = 1'b1; ctrl.is_arith = 1'b1; ctrl.is_signed = 1'b1; ctrl.is_sub = 1'b1; end
      OP_ADDU: begin ctrl.valid = 1'b1; ctrl.is_arith = 1'b1; end
      OP_SUBU: begin ctrl.valid = 1'b1; ctrl.is_arith = 1'b1; ctrl.is_sub = 1'b1; end
      OP_AND:  begin ctrl.valid = 1'b1; ctrl.bw_sel = BW_AND; end
      OP_OR:   begin ctrl.valid = 1'b1; ctrl.bw_sel = BW_OR; end
      OP_XOR:  begin ctrl.valid = 1'b1; ctrl.bw_sel = BW_XOR; end
      OP_CMPS: begin ctrl.valid = 1'b1; ctrl.is_arith = 1'b1; ctrl.is_signed = 1'b1; ctrl.is_sub = 1'b1; ctrl.is_cmp = 1'b1; end
      OP_CMPU: begin ctrl.valid = 1'b1; ctrl.is_arith = 1'b1; ctrl.is_sub = 1'b1; ctrl.is_cmp = 1'b1; end
      default: ctrl = '0;
    endcase
  end
endmodule

// File: rtl/alu16_addsub.sv
module alu16_addsub #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             sub,
  output logic [WIDTH-1:0] sum,
  output logic             carry,
  output logic             sovf
);
  localparam int MSB = WIDTH - 1;
  logic [WIDTH:0] ext;

  always_comb begin
    if (sub) ext = {1'b0, a} - {1'b0, b};
    else     ext = {1'b0, a} + {1'b0, b};
    sum   = ext[MSB:0];
    carry = ext[WIDTH];
    if (sub) sovf = (a[MSB] != b[MSB]) && (ext[MSB] != a[MSB]);
    else     sovf = (a[MSB] == b[MSB]) && (ext[MSB] != a[MSB]);
  end
endmodule

// File: rtl/alu16_bitwise.sv
module alu16_bitwise
  import alu16_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  bw_sel_e          sel,
  output logic [WIDTH-1:0] y
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_comb begin
      case (sel)
        BW_AND:  y[i] = a[i] & b[i];
        BW_OR:   y[i] = a[i] | b[i];
        BW_XOR:  y[i] = a[i] ^ b[i];
        default: y[i] = b[i];
      endcase
    end
  end
endmodule

// File: rtl/alu16_flagcalc.sv
module alu16_flagcalc
  import alu16_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0]  res,
  input  logic              is_arith,
  input  logic              is_signed,
  input  logic              carry,
  input  logic              sovf,
  output logic [FLAG_W-1:0] nxt
);
  localparam int MSB = WIDTH - 1;

  always_comb begin
    nxt = '0;
    nxt[FLG_ZERO] = (res == '0);
    if (!is_arith) begin
      nxt[FLG_SIGN] = res[MSB];
      nxt[FLG_OVF]  = 1'b0;
    end else if (is_signed) begin
      nxt[FLG_SIGN] = res[MSB];
      nxt[FLG_OVF]  = sovf;
    end else begin
      nxt[FLG_SIGN] = 1'b0;
      nxt[FLG_OVF]  = carry;
    end
  end
endmodule

// File: rtl/alu16_flagged.sv
module alu16_flagged
  import alu16_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [WIDTH-1:0]      a,
  input  logic [WIDTH-1:0]      b,
  input  logic [3:0]            op,
  input  logic                  flag_we,
  output logic [WIDTH-1:0]      result,
  output logic                  wb_en,
  output logic [2:0]            flags
);
  alu_ctrl_t         ctrl;
  logic [WIDTH-1:0]  arith_y;
  logic [WIDTH-1:0]  bw_y;
  logic              carry;
  logic              sovf;
  logic [FLAG_W-1:0] nxt_flags;

  alu16_decode u_dec (.op(op), .ctrl(ctrl));

  alu16_addsub #(.WIDTH(WIDTH)) u_arith (
    .a(a), .b(b), .sub(ctrl.is_sub),
    .sum(arith_y), .carry(carry), .sovf(sovf)
  );

  alu16_bitwise #(.WIDTH(WIDTH)) u_bw (
    .a(a), .b(b), .sel(ctrl.bw_sel), .y(bw_y)
  );

  always_comb begin
    if (!ctrl.valid)        result = '0;
    else if (ctrl.is_arith) result = arith_y;
    else                    result = bw_y;
    wb_en = ctrl.valid & ~ctrl.is_cmp;
  end

  alu16_flagcalc #(.WIDTH(WIDTH)) u_fc (
    .res(result), .is_arith(ctrl.is_arith), .is_signed(ctrl.is_signed),
    .carry(carry), .sovf(sovf), .nxt(nxt_flags)
  );

  always_ff @(posedge clk) begin
    if (rst)                         flags <= '0;
    else if (flag_we && ctrl.valid)  flags <= nxt_flags;
  end
endmodule

// File: rtl/alu16_flagged_chk.sv
module alu16_flagged_chk #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [WIDTH-1:0] a,
  input logic [WIDTH-1:0] b,
  input logic [3:0]       op,
  input logic             flag_we,
  input logic [WIDTH-1:0] result,
  input logic             wb_en,
  input logic [2:0]       flags
);
  localparam int MSB = WIDTH - 1;

  a_r9_reset_clears: assert property (@(posedge clk) rst |=> flags == 3'b000);

  a_r8_hold_without_we: assert property (@(posedge clk) disable iff (rst)
    !flag_we |=> $stable(flags));

  a_r10_unassigned_quiet: assert property (@(posedge clk) disable iff (rst)
    (op >= 4'd10) |-> (!wb_en && result == '0));

  a_r10_unassigned_keeps_flags: assert property (@(posedge clk) disable iff (rst)
    (op >= 4'd10) |=> $stable(flags));

  a_r6_compare_no_wb: assert property (@(posedge clk) disable iff (rst)
    (op == 4'd8 || op == 4'd9) |-> !wb_en);

  a_r7_wb_for_writers: assert property (@(posedge clk) disable iff (rst)
    (op <= 4'd7) |-> wb_en);

  a_r2_load_passes_b: assert property (@(posedge clk) disable iff (rst)
    (op == 4'd0) |-> (result == b));

  a_r3_zero_follows_result: assert property (@(posedge clk) disable iff (rst)
    (flag_we && op <= 4'd9) |=> (flags[2] == ($past(result) == '0)));

  a_r4_no_sign_logical: assert property (@(posedge clk) disable iff (rst)
    (flag_we && (op == 4'd3 || op == 4'd4 || op == 4'd9)) |=> !flags[1]);

  a_r5_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (flag_we && (op == 4'd0 || op == 4'd5 || op == 4'd6 || op == 4'd7)) |=> !flags[0]);

  a_r3_add_overflow: assert property (@(posedge clk) disable iff (rst)
    (flag_we && op == 4'd1 && a[MSB] == b[MSB] && result[MSB] != a[MSB]) |=> flags[0]);
endmodule

bind alu16_flagged alu16_flagged_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst(rst), .a(a), .b(b), .op(op), .flag_we(flag_we),
  .result(result), .wb_en(wb_en), .flags(flags)
);

// File: tb/sim_alu16_flagged.sv
module sim_alu16_flagged;
  localparam int CLK_PERIOD = 10;
  localparam int QTR = CLK_PERIOD / 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] a = '0;
  logic [15:0] b = '0;
  logic [3:0]  op = '0;
  logic        flag_we = 1'b0;
  logic [15:0] result;
  logic        wb_en;
  logic [2:0]  flags;

  int n_checks = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu16_flagged u0 (
    .clk(clk), .rst(rst), .a(a), .b(b), .op(op), .flag_we(flag_we),
    .result(result), .wb_en(wb_en), .flags(flags)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic run_op(input string req, input logic [3:0] o, input logic [15:0] x,
                        input logic [15:0] y, input logic we,
                        input logic [15:0] exp_res, input logic exp_wb,
                        input logic [2:0] exp_fl);
    @(negedge clk);
    op = o; a = x; b = y; flag_we = we;
    #(QTR);
    check(req, "result", int'(result), int'(exp_res));
    check(req, "wb_en", int'(wb_en), int'(exp_wb));
    @(posedge clk);
    #(QTR);
    check(req, "flags", int'(flags), int'(exp_fl));
    flag_we = 1'b0;
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (2) @(posedge clk);
    #(QTR);
    check("R9", "flags after reset", int'(flags), 0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_signed;
    run_op("R1/R3", 4'd1, 16'h7FFF, 16'h0001, 1, 16'h8000, 1, 3'b011);
    run_op("R1/R3", 4'd2, 16'h8000, 16'h0001, 1, 16'h7FFF, 1, 3'b001);
    run_op("R3",    4'd2, 16'h1234, 16'h1234, 1, 16'h0000, 1, 3'b100);
    run_op("R3",    4'd1, 16'hFFFE, 16'h0001, 1, 16'hFFFF, 1, 3'b010);
  endtask

  task automatic t_logical;
    run_op("R1/R4", 4'd3, 16'hFFFF, 16'h0001, 1, 16'h0000, 1, 3'b101);
    run_op("R4",    4'd4, 16'h0003, 16'h0005, 1, 16'hFFFE, 1, 3'b001);
    run_op("R4",    4'd3, 16'h8000, 16'h0001, 1, 16'h8001, 1, 3'b000);
  endtask

  task automatic t_bitwise;
    run_op("R4",    4'd3, 16'hFFFF, 16'h0002, 1, 16'h0001, 1, 3'b001);
    run_op("R2/R5", 4'd5, 16'hF0F0, 16'h0F0F, 1, 16'h0000, 1, 3'b100);
    run_op("R2/R5", 4'd6, 16'h8000, 16'h0001, 1, 16'h8001, 1, 3'b010);
    run_op("R3",    4'd1, 16'h7FFF, 16'h0001, 1, 16'h8000, 1, 3'b011);
    run_op("R2/R5", 4'd7, 16'hFFFF, 16'h7FFF, 1, 16'h8000, 1, 3'b010);
    run_op("R2/R5", 4'd0, 16'h1111, 16'h0000, 1, 16'h0000, 1, 3'b100);
    run_op("R2/R7", 4'd0, 16'h1111, 16'h4321, 1, 16'h4321, 1, 3'b000);
  endtask

  task automatic t_compare;
    run_op("R6", 4'd8, 16'h0003, 16'h0005, 1, 16'hFFFE, 0, 3'b010);
    run_op("R6", 4'd8, 16'h8000, 16'h0001, 1, 16'h7FFF, 0, 3'b001);
    run_op("R6", 4'd9, 16'h0003, 16'h0005, 1, 16'hFFFE, 0, 3'b001);
    run_op("R6", 4'd9, 16'h0007, 16'h0007, 1, 16'h0000, 0, 3'b100);
  endtask

  task automatic t_hold;
    run_op("R8", 4'd1, 16'h7FFF, 16'h0001, 0, 16'h8000, 1, 3'b100);
    run_op("R8", 4'd3, 16'hFFFF, 16'h0001, 0, 16'h0000, 1, 3'b100);
  endtask

  task automatic t_unassigned;
    run_op("R10", 4'd12, 16'h0005, 16'h0005, 1, 16'h0000, 0, 3'b100);
    run_op("R10", 4'd15, 16'hFFFF, 16'h0001, 1, 16'h0000, 0, 3'b100);
  endtask

  task automatic t_reset_mid;
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #(QTR);
    check("R9", "flags after mid-run reset", int'(flags), 0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    t_reset();
    t_signed();
    t_logical();
    t_bitwise();
    t_compare();
    t_hold();
    t_unassigned();
    t_reset_mid();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule